// File: doc/BRIEF.md
# Sticky Interrupt Status Collector

This block gathers condition signals from five sources into one status register that software reads. The sources are an ADC positive-overflow condition, clock-error conditions for two serial ports, and left and right auto-mute conditions of a DAC. Each status bit latches when its source produces a qualifying event. The bit stays set until the host reads the status register, and that read clears it.

The sources are grouped into four classes: ADC overflow, serial port 1, serial port 2, and the DAC pair. Each class has a 2-bit trigger-mode field that selects which change of the condition counts as an event. Each source also has its own mask bit. The unmasked sources are ORed into one registered, active-low interrupt line. The live ADC overflow level is also passed out on a separate output that does not latch.

The host reaches the block through a simple register port. A read strobe with an address returns data one cycle later. A write strobe with an address and data updates the mask and mode registers.

Top module: `sirq_collector`

## Requirements
- R1: Status bits sit at address 0 as bit 0 ADC overflow, bit 1 serial port 1 clock error, bit 2 serial port 2 clock error, bit 3 DAC left mute, bit 4 DAC right mute, with upper bits zero. Read data appears on the cycle after the read strobe.
- R2: A latched status bit stays set after its condition goes away, until the status register is read.
- R3: A read of address 0 returns the bits held before the read and clears them. An event in the same cycle as that read leaves its bit set.
- R4: Trigger mode 00 latches on the condition's rising edge only.
- R5: Trigger mode 01 latches on the condition's falling edge only.
- R6: Trigger mode 10 latches on both edges.
- R7: Trigger mode 11 is level mode. The status bit is set while the condition is high, and the interrupt follows the live condition rather than the latched bit.
- R8: A mask bit of 1 keeps its source off the interrupt line while its status bit still latches.
- R9: irq_n is active low. It is a registered OR of all unmasked sources, so it changes one cycle after the status bit or live level that drives it.
- R10: After reset, status reads 0x00, mask reads 0x1F, mode reads 0x00 and irq_n is high.
- R11: Address 1 holds the mask register with bit i masking source i. Address 2 holds the mode register with bits [2c+1:2c] for class c, where class 0 is ADC, class 1 is serial port 1, class 2 is serial port 2 and class 3 is the DAC pair. Both registers read back what was written. Writes to address 0 are ignored.
- R12: ovfl_live_o follows the ADC overflow condition directly and does not latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_cond_i | input | 5 | Live condition per source, in the same bit order as the status register |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Registered read data |
| irq_n_o | output | 1 | Active-low interrupt |
| ovfl_live_o | output | 1 | Live ADC overflow level |

## Verification
The bench times a rising condition to land in the same cycle as a clearing read. A design that let the clear win would lose that event, and the following read would return zero.

Each trigger mode gets an edge its mode should ignore. A swapped or mis-sliced mode field would then latch that ignored edge.

In level mode the bench drops the condition while the status bit is still set. An interrupt fed from the latched bit would stay low in that case.

A masked source that still pulls the interrupt low, and a write to the status address that reaches the mask, are both caught by the bench reading back at the ports.

// File: rtl/sirq_pkg.sv
// Package: shared constants, trigger-mode encoding and the source-to-class map
// for the sticky interrupt status collector.
package sirq_pkg;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'b00,
        TRIG_FALL  = 2'b01,
        TRIG_BOTH  = 2'b10,
        TRIG_LEVEL = 2'b11
    } trig_mode_e;

    localparam logic [1:0] ADDR_STATUS = 2'd0;
    localparam logic [1:0] ADDR_MASK   = 2'd1;
    localparam logic [1:0] ADDR_MODE   = 2'd2;

    // Sources past the last class all share the last class (the DAC pair).
    function automatic int src_class(input int src, input int num_class);
        return (src >= num_class - 1) ? num_class - 1 : src;
    endfunction

endpackage

// File: rtl/sirq_edge_qual.sv
// Module: sirq_edge_qual
// Turns each live source condition into a one-cycle "set" request, according
// to the 2-bit trigger mode of the source's class. It also flags the sources
// whose class is in level mode.
// Assumes: the conditions are synchronous to clk, and the previous condition
// value resets to 0, so a condition already high at reset release counts as
// a rising edge.
module sirq_edge_qual #(
    parameter int NUM_SRC   = 5,
    parameter int NUM_CLASS = 4,
    localparam int MODE_W   = 2 * NUM_CLASS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] cond_i,
    input  logic [MODE_W-1:0]  mode_i,
    output logic [NUM_SRC-1:0] set_o,
    output logic [NUM_SRC-1:0] level_o
);
    import sirq_pkg::*;

    logic [NUM_SRC-1:0] cond_q;

    // Remember the previous condition value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= '0;
        else        cond_q <= cond_i;
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        localparam int CLS = src_class(s, NUM_CLASS);
        trig_mode_e mode;
        logic       rise;
        logic       fall;

        assign mode = trig_mode_e'(mode_i[2*CLS +: 2]);
        assign rise = cond_i[s] & ~cond_q[s];
        assign fall = ~cond_i[s] & cond_q[s];

        // Select which change (or level) of the condition is an event.
        always_comb begin
            unique case (mode)
                TRIG_RISE:  set_o[s] = rise;
                TRIG_FALL:  set_o[s] = fall;
                TRIG_BOTH:  set_o[s] = rise | fall;
                TRIG_LEVEL: set_o[s] = cond_i[s];
                default:    set_o[s] = 1'b0;
            endcase
        end

        assign level_o[s] = (mode == TRIG_LEVEL);

        // R5: in falling-edge mode an event only comes after the condition was high.
        p_fall_needs_prior_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == TRIG_FALL && set_o[s]) |-> (!cond_i[s] && cond_q[s]));
    end

endmodule

// File: rtl/sirq_status.sv
// Module: sirq_status
// Holds the sticky status bits. A set request latches its bit, and a
// clearing read drops the bits. A set request in the same cycle as the
// clear wins, so no event is lost.
// Assumes: clr_i is a one-cycle strobe that comes from a status-register read.
module sirq_status #(
    parameter int NUM_SRC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic               clr_i,
    output logic [NUM_SRC-1:0] status_o
);
    logic [NUM_SRC-1:0] status_q;

    // Latch events, clear on read, and give events priority over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     status_q <= '0;
        else if (clr_i) status_q <= set_i;
        else            status_q <= status_q | set_i;
    end

    assign status_o = status_q;

    // R2: without a clear, a set bit stays set.
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R3: an event is never lost, even when it collides with a clear.
    p_event_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));

    // R3: a clear with no event leaves every bit at zero.
    p_clear_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_i == '0) |=> (status_q == '0));

endmodule

// File: rtl/sirq_host_regs.sv
// Module: sirq_host_regs
// Holds the mask and mode registers written by the host, builds the
// registered read data, and raises the status clear strobe on a read of
// the status address.
// Assumes: DATA_W is wide enough for both NUM_SRC mask bits and the mode bits.
module sirq_host_regs #(
    parameter int NUM_SRC   = 5,
    parameter int NUM_CLASS = 4,
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 8,
    localparam int MODE_W   = 2 * NUM_CLASS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    input  logic [NUM_SRC-1:0] status_i,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [MODE_W-1:0]  mode_o,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               clr_o
);
    import sirq_pkg::*;

    logic [NUM_SRC-1:0] mask_q;
    logic [MODE_W-1:0]  mode_q;
    logic [DATA_W-1:0]  rd_data_q;
    logic [DATA_W-1:0]  rd_mux;

    // Host writes update the mask and mode; the status address is not writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            mode_q <= '0;
        end else if (wr_en_i) begin
            if (wr_addr_i == ADDR_W'(ADDR_MASK)) mask_q <= wr_data_i[NUM_SRC-1:0];
            if (wr_addr_i == ADDR_W'(ADDR_MODE)) mode_q <= wr_data_i[MODE_W-1:0];
        end
    end

    // Choose the register value that the read address selects.
    always_comb begin
        unique case (rd_addr_i)
            ADDR_W'(ADDR_STATUS): rd_mux = DATA_W'(status_i);
            ADDR_W'(ADDR_MASK):   rd_mux = DATA_W'(mask_q);
            ADDR_W'(ADDR_MODE):   rd_mux = DATA_W'(mode_q);
            default:              rd_mux = '0;
        endcase
    end

    // Register the read data one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data_q <= '0;
        else if (rd_en_i) rd_data_q <= rd_mux;
    end

    assign clr_o     = rd_en_i && (rd_addr_i == ADDR_W'(ADDR_STATUS));
    assign mask_o    = mask_q;
    assign mode_o    = mode_q;
    assign rd_data_o = rd_data_q;

    // R11: a write to the status address changes neither mask nor mode.
    p_status_wr_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_W'(ADDR_STATUS)) |=> ($stable(mask_q) && $stable(mode_q)));

    // R10: the cycle reset is released, every source is still masked.
    p_mask_reset_r10: assert property (@(posedge clk)
        $rose(rst_n) |-> (mask_q == '1));

endmodule

// File: rtl/sirq_irq_out.sv
// Module: sirq_irq_out
// Combines the sources into the registered active-low interrupt. A source
// in level mode contributes its live condition; any other source contributes
// its latched status bit. A set mask bit removes the source.
// Assumes: the inputs are synchronous to clk.
module sirq_irq_out #(
    parameter int NUM_SRC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] status_i,
    input  logic [NUM_SRC-1:0] cond_i,
    input  logic [NUM_SRC-1:0] level_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic               irq_n_o
);
    logic [NUM_SRC-1:0] contrib;
    logic               irq_n_q;

    // Pick the live condition or the latched bit for each source, then mask it.
    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            contrib[s] = ~mask_i[s] & (level_i[s] ? cond_i[s] : status_i[s]);
        end
    end

    // Register the active-low OR of every contribution.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n_q <= 1'b1;
        else        irq_n_q <= ~|contrib;
    end

    assign irq_n_o = irq_n_q;

    // R8: with every source masked, the interrupt stays inactive.
    p_all_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '1) |=> irq_n_q);

    // R9: an unmasked latched status bit outside level mode pulls irq low next cycle.
    p_unmasked_status_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_i & ~mask_i & ~level_i) != '0) |=> !irq_n_q);

    // R7: an unmasked level-mode condition pulls irq low next cycle.
    p_level_live_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cond_i & ~mask_i & level_i) != '0) |=> !irq_n_q);

endmodule

// File: rtl/sirq_collector.sv
// Module: sirq_collector (top)
// Sticky interrupt status collector. It qualifies source conditions by
// trigger mode, latches them into clear-on-read status bits, drives a
// masked active-low interrupt, and passes the live ADC overflow level out.
// Assumes: source bit 0 is the ADC overflow condition, and all inputs are
// synchronous to clk.
module sirq_collector #(
    parameter int NUM_SRC   = 5,
    parameter int NUM_CLASS = 4,
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 8,
    parameter int OVFL_IDX  = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_cond_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               irq_n_o,
    output logic               ovfl_live_o
);
    localparam int MODE_W = 2 * NUM_CLASS;

    logic [NUM_SRC-1:0] set_req;
    logic [NUM_SRC-1:0] level_sel;
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] mask;
    logic [MODE_W-1:0]  mode;
    logic               status_clr;

    sirq_edge_qual #(.NUM_SRC(NUM_SRC), .NUM_CLASS(NUM_CLASS)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond_i (src_cond_i),
        .mode_i (mode),
        .set_o  (set_req),
        .level_o(level_sel)
    );

    sirq_status #(.NUM_SRC(NUM_SRC)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_req),
        .clr_i   (status_clr),
        .status_o(status)
    );

    sirq_host_regs #(
        .NUM_SRC  (NUM_SRC),
        .NUM_CLASS(NUM_CLASS),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .rd_en_i  (rd_en_i),
        .rd_addr_i(rd_addr_i),
        .status_i (status),
        .mask_o   (mask),
        .mode_o   (mode),
        .rd_data_o(rd_data_o),
        .clr_o    (status_clr)
    );

    sirq_irq_out #(.NUM_SRC(NUM_SRC)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .status_i(status),
        .cond_i  (src_cond_i),
        .level_i (level_sel),
        .mask_i  (mask),
        .irq_n_o (irq_n_o)
    );

    assign ovfl_live_o = src_cond_i[OVFL_IDX];

endmodule

// File: tb/sirq_collector_tb.sv
// Directed bench for sirq_collector. There is one task per scenario, and
// each task checks its own results.
module sirq_collector_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] cond = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq_n;
    logic       ovfl_live;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk; // 200 MHz

    sirq_collector u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_cond_i (cond),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .rd_en_i    (rd_en),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .irq_n_o    (irq_n),
        .ovfl_live_o(ovfl_live)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    // Return to a clean state: conditions low, status cleared, given mask and mode.
    task automatic prepare(input logic [7:0] mask, input logic [7:0] mode);
        logic [7:0] d;
        cond = '0;
        write_reg(2'd2, mode);
        write_reg(2'd1, mask);
        wait_cyc(2);
        read_reg(2'd0, d);
        wait_cyc(2);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R10 irq_n after reset", {7'd0, irq_n}, 8'h01);
        read_reg(2'd0, d); check("R10 status reset", d, 8'h00);
        read_reg(2'd1, d); check("R10 mask reset", d, 8'h1F);
        read_reg(2'd2, d); check("R10 mode reset", d, 8'h00);
    endtask

    task automatic t_regs;
        logic [7:0] d;
        write_reg(2'd1, 8'h0A);
        write_reg(2'd2, 8'hC6);
        write_reg(2'd0, 8'hFF);
        read_reg(2'd1, d); check("R11 mask readback after status write", d, 8'h0A);
        read_reg(2'd2, d); check("R11 mode readback", d, 8'hC6);
        read_reg(2'd0, d); check("R11 status unaffected by write", d, 8'h00);
    endtask

    task automatic t_rise;
        logic [7:0] d;
        prepare(8'h00, 8'h00);
        cond[1] = 1'b1;
        wait_cyc(2);
        check("R9 irq low two cycles after rise", {7'd0, irq_n}, 8'h00);
        cond[1] = 1'b0;
        wait_cyc(2);
        read_reg(2'd0, d); check("R1 R2 R4 status after rise then drop", d, 8'h02);
        wait_cyc(1);
        check("R9 irq released after clearing read", {7'd0, irq_n}, 8'h01);
        read_reg(2'd0, d); check("R3 status cleared by read", d, 8'h00);
        cond[1] = 1'b1;
        wait_cyc(2);
        read_reg(2'd0, d);
        cond[1] = 1'b0;
        wait_cyc(2);
        read_reg(2'd0, d); check("R4 falling edge ignored in rise mode", d, 8'h00);
    endtask

    task automatic t_fall;
        logic [7:0] d;
        prepare(8'h00, 8'h44); // class1 and class3 set to 01
        cond[1] = 1'b1; cond[3] = 1'b1; cond[4] = 1'b1;
        wait_cyc(2);
        read_reg(2'd0, d); check("R5 rise ignored in fall mode", d, 8'h00);
        cond[1] = 1'b0; cond[3] = 1'b0; cond[4] = 1'b0;
        wait_cyc(2);
        read_reg(2'd0, d); check("R5 fall latches sp1 and dac pair", d, 8'h1A);
    endtask

    task automatic t_both;
        logic [7:0] d;
        prepare(8'h00, 8'h20); // class2 set to 10
        cond[2] = 1'b1;
        wait_cyc(2);
        read_reg(2'd0, d); check("R6 rise latches in both mode", d, 8'h04);
        cond[2] = 1'b0;
        wait_cyc(2);
        read_reg(2'd0, d); check("R6 fall latches in both mode", d, 8'h04);
    endtask

    task automatic t_level;
        logic [7:0] d;
        prepare(8'h00, 8'h03); // class0 set to 11
        cond[0] = 1'b1;
        wait_cyc(1);
        check("R12 live overflow high", {7'd0, ovfl_live}, 8'h01);
        wait_cyc(1);
        check("R7 irq low while level high", {7'd0, irq_n}, 8'h00);
        cond[0] = 1'b0;
        wait_cyc(1);
        check("R12 live overflow low", {7'd0, ovfl_live}, 8'h00);
        wait_cyc(1);
        check("R7 irq follows live level not status", {7'd0, irq_n}, 8'h01);
        read_reg(2'd0, d); check("R7 status latched in level mode", d, 8'h01);
    endtask

    task automatic t_mask;
        logic [7:0] d;
        prepare(8'h1F, 8'h00);
        cond[3] = 1'b1;
        wait_cyc(3);
        check("R8 masked source leaves irq high", {7'd0, irq_n}, 8'h01);
        cond[3] = 1'b0;
        read_reg(2'd0, d); check("R8 masked source still latches", d, 8'h08);
    endtask

    task automatic t_collide;
        logic [7:0] d;
        prepare(8'h00, 8'h00);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 2'd0; cond[4] = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R3 colliding read returns old value", rd_data, 8'h00);
        cond[4] = 1'b0;
        wait_cyc(1);
        read_reg(2'd0, d); check("R3 event kept across clearing read", d, 8'h10);
        read_reg(2'd0, d); check("R3 cleared after next read", d, 8'h00);
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_regs();
        t_rise();
        t_fall();
        t_both();
        t_level();
        t_mask();
        t_collide();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule